// File: doc/BRIEF.md
# Signal Detector with Loss-of-Signal Timer

This block watches a stream of complex baseband samples and decides whether a signal is present. For every accepted I/Q pair it forms the instantaneous power I*I + Q*Q as an unsigned word twice the sample width. It then compares a window of that word against a programmable threshold, which yields a per-sample detect flag.

A signal-present / loss-of-signal status is kept alongside the flag. Any sample at or above the threshold sets the status to present at once. Loss is declared only after a run of below-threshold samples lasts long enough, and a programmable sample count sets that length. The status ignores cycles that carry no sample.

Typical use is in a receive channel, where it gates gain control or reports channel activity. The threshold and the timer value are static configuration inputs.

Top module: `sig_detect_top`

## Requirements
- R1: The power of a sample is I*I + Q*Q, with I and Q taken as 16-bit two's-complement values, giving an unsigned 32-bit result (e.g. I = -16, Q = 0 gives 256; I = Q = -32768 gives 2^31).
- R2: The detect flag compares power bits [23:8] as an unsigned 16-bit value with the threshold. The sample counts as above when that slice is greater than or equal to the threshold. Power bits [7:0] never affect the outcome.
- R3: If any of power bits [31:24] is set, the sample counts as above whatever the threshold.
- R4: A sample accepted with the valid strobe high on a clock edge produces a one-cycle pulse on the result-valid output two edges later. The detect flag updates on that same edge and holds its value until the next result.
- R5: An above-threshold sample sets present high and loss low on the edge its result appears, and it clears the no-signal run count.
- R6: With timer value T, loss is declared on the result of the (T+1)-th consecutive below-threshold sample. T = 0 declares loss on the first one.
- R7: Once loss is declared, further below-threshold samples keep the block in loss without wrapping. Cycles without a valid sample leave the status unchanged.
- R8: Synchronous reset sets loss high, present low, result-valid low and the detect flag low, and it clears the run count.
- R9: An above-threshold sample in the middle of a below-threshold run restarts the count, so a fresh run of T+1 below-threshold samples is needed to declare loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Sample strobe |
| in_re_i | input | 16 | In-phase sample, two's complement |
| in_im_i | input | 16 | Quadrature sample, two's complement |
| cfg_thresh_i | input | 16 | Threshold, LSB weighted as power bit 8 |
| cfg_timer_i | input | 16 | Count of tolerated no-signal samples before loss |
| det_valid_o | output | 1 | One-cycle pulse when a sample result is available |
| det_above_o | output | 1 | Detect flag of the most recent sample |
| present_o | output | 1 | Signal-present status |
| los_o | output | 1 | Loss-of-signal status |

## Verification
The bench uses the default parameters: 16-bit samples, a 16-bit threshold placed at power bit 8, and a 16-bit timer. With these values the slice edges are reachable with small sample magnitudes: 255 squared lands exactly on a slice value, and 4095 squared fills the top of the slice. A magnitude of 4096 is the first to reach the bits above the slice, which checks the forced-above path. Small timer values (0, 2, 3) bring each loss boundary within a few samples, and these tests also cover saturation and restart.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic {
        LINK_LOST    = 1'b0,
        LINK_PRESENT = 1'b1
    } link_state_e;

endpackage

// File: rtl/sd_squarer.sv
module sd_squarer #(
    parameter int SAMPLE_W = 16,
    localparam int PW_W    = 2 * SAMPLE_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] in_re_i,
    input  logic [SAMPLE_W-1:0] in_im_i,
    output logic                pw_valid_o,
    output logic [PW_W-1:0]     pw_o
);

    typedef struct packed {
        logic            vld;
        logic [PW_W-1:0] pw;
    } sq_state_t;

    sq_state_t st_d, st_q;

    logic signed [SAMPLE_W-1:0] re_s, im_s;
    logic signed [PW_W-1:0]     re_ext, im_ext;
    logic signed [PW_W-1:0]     re_sq, im_sq;

    always_comb begin
        re_s   = signed'(in_re_i);
        im_s   = signed'(in_im_i);
        re_ext = PW_W'(re_s);
        im_ext = PW_W'(im_s);
        re_sq  = re_ext * re_ext;
        im_sq  = im_ext * im_ext;
        st_d     = st_q;
        st_d.vld = in_valid_i;
        if (in_valid_i) begin
            st_d.pw = unsigned'(re_sq) + unsigned'(im_sq);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pw_valid_o = st_q.vld;
    assign pw_o       = st_q.pw;

endmodule

// File: rtl/sd_compare.sv
module sd_compare #(
    parameter int PW_W       = 32,
    parameter int THRESH_W   = 16,
    parameter int THRESH_LSB = 8,
    localparam int SLICE_TOP = THRESH_LSB + THRESH_W
) (
    input  logic [PW_W-1:0]     pw_i,
    input  logic [THRESH_W-1:0] thresh_i,
    output logic                above_o
);

    logic [THRESH_W-1:0] slice;
    logic                over_top;

    assign slice = pw_i[THRESH_LSB +: THRESH_W];

    generate
        if (SLICE_TOP < PW_W) begin : g_high_bits
            assign over_top = |pw_i[PW_W-1:SLICE_TOP];
        end else begin : g_no_high_bits
            assign over_top = 1'b0;
        end
    endgenerate

    always_comb begin
        above_o = over_top || (slice >= thresh_i);
    end

endmodule

// File: rtl/sd_loss_timer.sv
module sd_loss_timer
    import sd_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               smp_valid_i,
    input  logic               smp_above_i,
    input  logic [TIMER_W-1:0] cfg_timer_i,
    output logic               det_valid_o,
    output logic               det_above_o,
    output logic               present_o,
    output logic               los_o
);

    typedef struct packed {
        link_state_e        link;
        logic [TIMER_W-1:0] run;
        logic               dv;
        logic               above;
    } lt_state_t;

    lt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.dv = smp_valid_i;
        if (smp_valid_i) begin
            st_d.above = smp_above_i;
            if (smp_above_i) begin
                st_d.link = LINK_PRESENT;
                st_d.run  = '0;
            end else if (st_q.link == LINK_PRESENT) begin
                if (st_q.run >= cfg_timer_i) begin
                    st_d.link = LINK_LOST;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.link  <= LINK_LOST;
            st_q.run   <= '0;
            st_q.dv    <= 1'b0;
            st_q.above <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_valid_o = st_q.dv;
    assign det_above_o = st_q.above;
    assign present_o   = (st_q.link == LINK_PRESENT);
    assign los_o       = (st_q.link == LINK_LOST);

endmodule

// File: rtl/sig_detect_top.sv
module sig_detect_top #(
    parameter int SAMPLE_W   = 16,
    parameter int THRESH_W   = 16,
    parameter int THRESH_LSB = 8,
    parameter int TIMER_W    = 16,
    localparam int PW_W      = 2 * SAMPLE_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] in_re_i,
    input  logic [SAMPLE_W-1:0] in_im_i,
    input  logic [THRESH_W-1:0] cfg_thresh_i,
    input  logic [TIMER_W-1:0]  cfg_timer_i,
    output logic                det_valid_o,
    output logic                det_above_o,
    output logic                present_o,
    output logic                los_o
);

    logic            pw_valid;
    logic [PW_W-1:0] pw;
    logic            above;

    sd_squarer #(
        .SAMPLE_W(SAMPLE_W)
    ) sq_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .in_valid_i (in_valid_i),
        .in_re_i    (in_re_i),
        .in_im_i    (in_im_i),
        .pw_valid_o (pw_valid),
        .pw_o       (pw)
    );

    sd_compare #(
        .PW_W       (PW_W),
        .THRESH_W   (THRESH_W),
        .THRESH_LSB (THRESH_LSB)
    ) cmp_i (
        .pw_i     (pw),
        .thresh_i (cfg_thresh_i),
        .above_o  (above)
    );

    sd_loss_timer #(
        .TIMER_W(TIMER_W)
    ) tmr_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .smp_valid_i (pw_valid),
        .smp_above_i (above),
        .cfg_timer_i (cfg_timer_i),
        .det_valid_o (det_valid_o),
        .det_above_o (det_above_o),
        .present_o   (present_o),
        .los_o       (los_o)
    );

endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
    parameter int TIMER_W = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               in_valid_i,
    input logic [TIMER_W-1:0] cfg_timer_i,
    input logic               det_valid_o,
    input logic               det_above_o,
    input logic               present_o,
    input logic               los_o
);

    assert_result_latency_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(in_valid_i, 2) |-> det_valid_o);

    assert_hit_gives_present_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (det_valid_o && det_above_o) |-> (present_o && !los_o));

    assert_loss_leaves_on_hit_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(los_o) |-> (det_valid_o && det_above_o));

    assert_loss_enters_on_miss_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(los_o) |-> (det_valid_o && !det_above_o));

    assert_zero_timer_immediate_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (det_valid_o && !det_above_o && ($past(cfg_timer_i) == '0)) |-> los_o);

    assert_idle_holds_status_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !det_valid_o |-> $stable(los_o));

endmodule

bind sig_detect_top sd_checker #(
    .TIMER_W(TIMER_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .cfg_timer_i (cfg_timer_i),
    .det_valid_o (det_valid_o),
    .det_above_o (det_above_o),
    .present_o   (present_o),
    .los_o       (los_o)
);

// File: tb/sig_detect_top_tb_top.sv
module sig_detect_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_re, in_im, thr, tmr;
    logic        det_valid, det_above, present, los;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sig_detect_top dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .in_valid_i   (in_valid),
        .in_re_i      (in_re),
        .in_im_i      (in_im),
        .cfg_thresh_i (thr),
        .cfg_timer_i  (tmr),
        .det_valid_o  (det_valid),
        .det_above_o  (det_above),
        .present_o    (present),
        .los_o        (los)
    );

    // fields: re, im, threshold, expected detect flag
    localparam int NV = 13;
    localparam logic [48:0] VEC [NV] = '{
        {16'h0010, 16'h0000, 16'h0001, 1'b1},  // 256 -> slice 1, equal
        {16'h0010, 16'h0000, 16'h0002, 1'b0},
        {16'h0000, 16'h0010, 16'h0001, 1'b1},
        {16'hFFF0, 16'h0000, 16'h0001, 1'b1},  // negative I, R1
        {16'h000F, 16'h000F, 16'h0001, 1'b1},  // 450 -> slice 1
        {16'h00FF, 16'h0000, 16'h00FE, 1'b1},  // 65025 -> slice 254
        {16'h00FF, 16'h0000, 16'h00FF, 1'b0},
        {16'h1000, 16'h0000, 16'hFFFF, 1'b1},  // bit 24 set, R3
        {16'h8000, 16'h8000, 16'hFFFF, 1'b1},  // 2^31, R1 and R3
        {16'h0FFF, 16'h0000, 16'hFFE0, 1'b1},  // slice 65504
        {16'h0FFF, 16'h0000, 16'hFFE1, 1'b0},
        {16'h0000, 16'h0000, 16'h0000, 1'b1},  // zero power, zero threshold
        {16'h000B, 16'h000B, 16'h0001, 1'b0}   // 242: low byte only
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // drive one sample, then sample outputs where its result appears (R4)
    task automatic send(input logic [15:0] re, input logic [15:0] im);
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = re;
        in_im    = im;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R4 valid pulse", {31'd0, det_valid}, 32'd1);
    endtask

    task automatic expect_state(input string req, input logic exp_los);
        check(req, {30'd0, los, present}, {30'd0, exp_los, ~exp_los});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_re = '0; in_im = '0;
        thr = 16'h0001; tmr = 16'd0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 los", {31'd0, los}, 32'd1);
        check("R8 present", {31'd0, present}, 32'd0);
        check("R8 det_valid", {31'd0, det_valid}, 32'd0);
        check("R8 det_above", {31'd0, det_above}, 32'd0);
        rst = 1'b0;

        // table: R1 R2 R3 detect flag; timer 0 so status follows the flag (R5, R6)
        for (int k = 0; k < NV; k++) begin
            thr = VEC[k][16:1];
            send(VEC[k][48:33], VEC[k][32:17]);
            check((k == 7 || k == 8) ? "R3 detect" : ((k == 3) ? "R1 detect" : "R2 detect"),
                  {31'd0, det_above}, {31'd0, VEC[k][0]});
            expect_state(VEC[k][0] ? "R5 table" : "R6 table", ~VEC[k][0]);
        end

        // R4: flag holds and valid drops between results
        @(negedge clk);
        check("R4 pulse ends", {31'd0, det_valid}, 32'd0);
        check("R4 flag holds", {31'd0, det_above}, 32'd0);

        // R6 with T = 3: loss on the 4th consecutive miss
        thr = 16'h0010;
        tmr = 16'd3;
        send(16'h0100, 16'h0000);              // hit
        expect_state("R5 hit", 1'b0);
        for (int m = 1; m <= 3; m++) begin
            send(16'h0001, 16'h0000);
            expect_state("R6 before limit", 1'b0);
        end
        send(16'h0001, 16'h0000);
        expect_state("R6 at limit", 1'b1);
        // R7 saturation: many more misses stay lost
        for (int m = 0; m < 20; m++) begin
            send(16'h0002, 16'h0000);
        end
        expect_state("R7 saturated", 1'b1);
        // R7 idle cycles leave status unchanged
        repeat (10) @(negedge clk);
        expect_state("R7 idle", 1'b1);
        send(16'h0100, 16'h0100);
        expect_state("R5 recover", 1'b0);

        // R9 with T = 2: a hit mid-run restarts the count
        tmr = 16'd2;
        send(16'h0001, 16'h0001);
        send(16'h0001, 16'h0001);
        expect_state("R9 two misses", 1'b0);
        send(16'h0100, 16'h0000);
        send(16'h0001, 16'h0001);
        send(16'h0001, 16'h0001);
        expect_state("R9 restarted", 1'b0);
        send(16'h0001, 16'h0001);
        expect_state("R9 third miss", 1'b1);

        // R7 idle while present
        send(16'h0100, 16'h0000);
        repeat (8) @(negedge clk);
        expect_state("R7 idle present", 1'b0);

        // R8 reset from present state
        do_reset();
        check("R8 los after run", {31'd0, los}, 32'd1);
        check("R8 det_above after run", {31'd0, det_above}, 32'd0);
        // R8 counter cleared: hit then T misses keeps present
        send(16'h0100, 16'h0000);
        send(16'h0001, 16'h0000);
        send(16'h0001, 16'h0000);
        expect_state("R8 fresh count", 1'b0);

        finish_run();
    end

endmodule